// File: doc/BRIEF.md
# Trimmed-Period Asynchronous Byte Transmitter

This block turns a byte into a ten-bit asynchronous serial frame and times every bit by counting system clock cycles. The frame begins with a low start bit, carries the eight data bits least significant first, and closes with a high stop bit. The line rests high between frames. A byte comes in over a valid/ready handshake, and the block drives the same bit value on two output lines.

A one-bit mode input picks one of two system clock standards, and each standard has its own whole-cycle bit period. Rounding the period to a whole number of cycles lets the edge times drift away from the ideal baud rate. To cancel that drift, the block makes one data bit per mode longer or shorter by a single cycle. After reset the output stays idle for a fixed span, longer than ten bit times, so that a receiver on the line can settle before the first frame.

Top module: `serial_trim_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both serial lines are high, `busy` is 0 and `in_ready` is 0.
- R2: After reset is released, `in_ready` stays low for exactly IDLE_CYCLES (350) clock cycles and rises in the cycle after the 350th rising edge. The serial lines stay high for that whole span, even if `in_valid` is held high. A reset during a frame returns the lines to high at once and restarts this span.
- R3: A byte is accepted on a rising edge at which both `in_valid` and `in_ready` are high. The frame starts in the next cycle with a start bit of 0. Data bit 0 follows and the other data bits come in ascending order, then a stop bit of 1. Both bits of `ser_out` carry the same value in every cycle.
- R4: In mode 0 every bit lasts 31 cycles, except data bit 6, which lasts 32, so a whole frame takes 311 cycles.
- R5: In mode 1 every bit lasts 29 cycles, except data bit 3, which lasts 28, so a whole frame takes 289 cycles.
- R6: The mode is taken from `mode` on the accepting edge only. Changing `mode` while a frame is in progress leaves that frame's bit lengths unchanged.
- R7: `in_ready` is low from the accepting edge through every cycle of the frame except the last cycle of the stop bit, in which it is high. A byte offered at that point is accepted there, and its start bit directly follows a stop bit of full length.
- R8: When no frame is in progress, both lines are high, however long the gap between frames.
- R9: `busy` is high from the cycle after acceptance through the last cycle of the stop bit, and low once a frame has ended with no new byte accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| mode | input | 1 | Clock standard: 0 = 31-cycle bits, 1 = 29-cycle bits |
| busy | output | 1 | A frame is on the line |
| ser_out | output | 2 | Serial line pair, both carrying the same bit |

## Verification
Two events can land on the same edge: the stop bit of one frame ends, and the next byte is accepted. The stop-bit counter must expire and a new frame must load in that one cycle. The bench provokes this by calling its frame task back to back, so `in_valid` is already high in the final stop cycle. It then requires that cycle to show `in_ready` high and the stop bit to have lasted its full length, and the very next cycle to show the low start bit. Every cycle of every bit is compared against the bit's value, and the lengths the bench expects (including the trimmed bit) come from its own formula for each mode. A misplaced edge therefore fails the check for the bit it belongs to.

// File: rtl/serial_trim_tx.sv
module serial_trim_tx #(
  parameter int BASE_M0     = 31,
  parameter int BASE_M1     = 29,
  parameter int TRIM_BIT_M0 = 6,
  parameter int TRIM_BIT_M1 = 3,
  parameter int IDLE_CYCLES = 350
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       mode,
  output logic       busy,
  output logic [1:0] ser_out
);
  localparam int SLOTS    = 10;
  localparam int MAX_BASE = (BASE_M0 > BASE_M1) ? BASE_M0 : BASE_M1;
  localparam int CNT_W    = $clog2(MAX_BASE + 2);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int INIT_W   = $clog2(IDLE_CYCLES + 1);

  logic              busy_q;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;
  logic [SLOTS-1:0]  frame;
  logic              mode_q;
  logic [INIT_W-1:0] init_cnt;

  function automatic logic [CNT_W-1:0] slot_last(input logic m, input logic [SLOT_W-1:0] s);
    int n;
    n = m ? BASE_M1 : BASE_M0;
    if (!m && int'(s) == TRIM_BIT_M0 + 1) n = n + 1;
    if (m && int'(s) == TRIM_BIT_M1 + 1) n = n - 1;
    return CNT_W'(n - 1);
  endfunction

  wire init_done = (init_cnt == INIT_W'(IDLE_CYCLES));
  wire last_slot = (slot == SLOT_W'(SLOTS - 1));
  wire bit_end   = busy_q && (cnt == '0);
  wire accept    = in_valid && in_ready;

  assign in_ready = init_done && (!busy_q || (bit_end && last_slot));
  assign busy     = busy_q;
  assign ser_out  = {2{busy_q ? frame[0] : 1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      slot     <= '0;
      cnt      <= '0;
      frame    <= '1;
      mode_q   <= 1'b0;
      init_cnt <= '0;
    end else begin
      if (!init_done) init_cnt <= init_cnt + 1'b1;
      if (accept) begin
        busy_q <= 1'b1;
        slot   <= '0;
        frame  <= {1'b1, in_data, 1'b0};
        mode_q <= mode;
        cnt    <= slot_last(mode, '0);
      end else if (busy_q) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (last_slot) begin
          busy_q <= 1'b0;
        end else begin
          slot  <= slot + 1'b1;
          frame <= {1'b1, frame[SLOTS-1:1]};
          cnt   <= slot_last(mode_q, slot + 1'b1);
        end
      end
    end
  end

  logic [INIT_W-1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != INIT_W'(IDLE_CYCLES)) age <= age + 1'b1;
  end

  a_r2_idle_before_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (age == INIT_W'(IDLE_CYCLES)));
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && ser_out == 2'b00));
  a_r3_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt != '0) |=> $stable(ser_out));
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !accept) |=> $stable(mode_q));
  a_r7_ready_low_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_slot) |-> !in_ready);
  a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && last_slot && !accept) |=> !busy_q);
endmodule

// File: tb/tb_serial_trim_tx.sv
module tb_serial_trim_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       mode = 1'b0;
  logic       in_ready, busy;
  logic [1:0] ser_out;

  always #4 clk = ~clk;

  serial_trim_tx dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .mode(mode), .busy(busy), .ser_out(ser_out)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int blen(input bit m, input int k);
    if (m) return (k == 4) ? 28 : 29;
    return (k == 7) ? 32 : 31;
  endfunction

  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'h40}, {1'b1, 8'h08}, {1'b0, 8'hAA}, {1'b1, 8'h55},
    {1'b0, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'h31}, {1'b1, 8'hF7}
  };

  task automatic xmit(input logic [7:0] d, input bit m, output int waited);
    int idle_bad;
    idle_bad = 0;
    in_data = d; mode = m; in_valid = 1'b1; waited = 0;
    while (!in_ready) begin
      @(negedge clk);
      waited++;
      if (ser_out !== 2'b11) idle_bad++;
    end
    check(idle_bad == 0, "R2", "line not idle while waiting", idle_bad, 0);
    @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      int errs, rdy_errs;
      logic expb;
      errs = 0; rdy_errs = 0;
      expb = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
      for (int c = 0; c < blen(m, k); c++) begin
        @(negedge clk);
        if (k == 0 && c == 0) begin in_valid = 1'b0; mode = ~m; end
        if (ser_out !== {2{expb}}) errs++;
        if (busy !== 1'b1) errs++;
        if (!(k == 9 && c == blen(m, k) - 1) && in_ready !== 1'b0) rdy_errs++;
      end
      if (m) check(errs == 0, "R5", $sformatf("mode1 bit slot %0d data %02h", k, d), errs, 0);
      else   check(errs == 0, "R4", $sformatf("mode0 bit slot %0d data %02h", k, d), errs, 0);
      check(rdy_errs == 0, "R7", $sformatf("ready during slot %0d", k), rdy_errs, 0);
    end
    check(in_ready === 1'b1, "R7", "ready in last stop cycle", int'(in_ready), 1);
  endtask

  task automatic gap(input int n);
    int errs;
    errs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ser_out !== 2'b11 || busy !== 1'b0) errs++;
    end
    check(errs == 0, "R8", $sformatf("idle gap of %0d", n), errs, 0);
  endtask

  initial begin
    int w;
    #3;
    check(ser_out === 2'b11 && busy === 1'b0 && in_ready === 1'b0, "R1", "state in reset",
          int'(ser_out), 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(ser_out === 2'b11 && busy === 1'b0 && in_ready === 1'b0, "R1", "state after release",
          int'(ser_out), 3);

    xmit(VEC[0][7:0], VEC[0][8], w);
    check(w == 350, "R2", "ready delay after reset", w, 350);

    for (int i = 1; i < 8; i++) begin
      xmit(VEC[i][7:0], VEC[i][8], w);
      check(w == 0, "R7", "back-to-back acceptance wait", w, 0);
    end

    in_valid = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && ser_out === 2'b11, "R9", "busy drops after frame", int'(busy), 0);
    gap(1);
    xmit(8'h6C, 1'b0, w);
    in_valid = 1'b0;
    gap(37);
    xmit(8'h93, 1'b1, w);
    in_valid = 1'b0;
    gap(5);

    // R6: mode flips mid-frame inside xmit; bit lengths were checked per the accepted mode
    in_data = 8'h5A; mode = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; mode = 1'b1;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ser_out === 2'b11 && busy === 1'b0 && in_ready === 1'b0, "R2", "reset mid-frame",
          int'(ser_out), 3);
    @(negedge clk);
    rst_n = 1'b1;
    xmit(8'hC3, 1'b1, w);
    check(w == 350, "R2", "ready delay after mid-frame reset", w, 350);
    in_valid = 1'b0;
    gap(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule